// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steers a microprogrammed control unit through a 128-word control store. It keeps the control address register, which drives the control-store address, and a one-deep return register for microcode subroutines. On every clock edge it reads the sequencing fields of the current microword and computes the next address. The fields are a two-bit condition selector, a two-bit branch kind and a seven-bit target. The conditions come from the indirect bit and opcode of the data register and from the accumulator.

There are four branch kinds. A conditional jump goes to the target or steps to the next address. A conditional call does the same and, when taken, saves the return point. A return goes back to the saved point. An opcode dispatch drops the four opcode bits of the data register into the middle of the address, so each instruction's routine starts on a four-word boundary. After reset the sequencer sits at address 64, where the instruction fetch routine lives.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_ni is low, car_o is 64 and the return register is cleared, so a return issued first after reset goes to address 0.
- R2: Within the 20-bit microword uword_i, the target is bits [6:0], the branch kind bits [8:7] and the condition selector bits [10:9]. Bits [19:11] have no effect on sequencing.
- R3: Condition selector encodings: 00 is always true, 01 is dr_i[15], 10 is ac_i[15], 11 is true when ac_i is all zeros.
- R4: Branch kind 00 (jump) loads the target when the condition is true, and car_o+1 otherwise.
- R5: Branch kind 01 (call), with the condition true, loads the target and saves car_o+1 in the return register. With the condition false it loads car_o+1.
- R6: Branch kind 10 (return) loads the return register whatever the condition.
- R7: Branch kind 11 (dispatch) loads {0, dr_i[14:11], 00} whatever the condition.
- R8: The step to car_o+1 wraps from 127 to 0, both for a jump or call not taken and for the saved return point.
- R9: The return register changes only on a taken call. A later taken call overwrites it, and a call not taken leaves it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uword_i | input | 20 | Current microword; only the sequencing fields are used |
| dr_i | input | 16 | Data register: indirect bit and opcode |
| ac_i | input | 16 | Accumulator: sign and zero status |
| car_o | output | 7 | Control address register, the control-store address |

## Verification
The bench goes after corners where a wrong design still looks plausible. A swapped condition encoding jumps on the sign when the zero flag was meant, and an accumulator of 0x8000 shows it. A sequencer that writes the return register on every call, taken or not, returns to the wrong place. So does one that forgets the increment when saving. A dispatch that shifts the opcode by the wrong amount, or lets the condition or the indirect bit leak in, lands off the four-word grid. An incrementer one bit too wide fails the step from 127, which must land on 0. Field decoding is tested with every unused microword bit set, and the reset value of the return register is observed through a return.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    COND_ONE  = 2'b00,
    COND_IND  = 2'b01,
    COND_SIGN = 2'b10,
    COND_ZERO = 2'b11
  } cond_sel_e;

  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;

  localparam int MAP_SHIFT = 2;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
#(
  parameter int DW = 16
) (
  input  cond_sel_e         sel_i,
  input  logic              ind_i,
  input  logic [DW-1:0]     ac_i,
  output logic              cond_o
);
  logic ac_zero;
  assign ac_zero = ~|ac_i;

  always_comb begin
    unique case (sel_i)
      COND_ONE:  cond_o = 1'b1;
      COND_IND:  cond_o = ind_i;
      COND_SIGN: cond_o = ac_i[DW-1];
      COND_ZERO: cond_o = ac_zero;
      default:   cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int AW    = 7,
  parameter int OPC_W = 4
) (
  input  br_kind_e          br_i,
  input  logic              cond_i,
  input  logic [AW-1:0]     ad_i,
  input  logic [AW-1:0]     car_i,
  input  logic [AW-1:0]     sbr_i,
  input  logic [OPC_W-1:0]  opc_i,
  output logic [AW-1:0]     car_d_o,
  output logic [AW-1:0]     link_o,
  output logic              sbr_we_o
);
  localparam int MAP_TOP = OPC_W + MAP_SHIFT;

  logic [AW-1:0] map_addr;

  // Width-exact increment: wraps at the top of the store
  assign link_o = car_i + {{(AW-1){1'b0}}, 1'b1};

  generate
    if (MAP_TOP < AW) begin : g_map_pad
      assign map_addr = {{(AW-MAP_TOP){1'b0}}, opc_i, {MAP_SHIFT{1'b0}}};
    end else begin : g_map_fit
      assign map_addr = {opc_i[AW-MAP_SHIFT-1:0], {MAP_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    car_d_o  = link_o;
    sbr_we_o = 1'b0;
    unique case (br_i)
      BR_JUMP: if (cond_i) car_d_o = ad_i;
      BR_CALL: if (cond_i) begin
        car_d_o  = ad_i;
        sbr_we_o = 1'b1;
      end
      BR_RET:  car_d_o = sbr_i;
      BR_MAP:  car_d_o = map_addr;
      default: car_d_o = link_o;
    endcase
  end
endmodule

// File: rtl/useq_addr_reg.sv
module useq_addr_reg #(
  parameter int AW       = 7,
  parameter int RST_ADDR = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] car_d_i,
  input  logic          sbr_we_i,
  input  logic [AW-1:0] link_i,
  output logic [AW-1:0] car_q_o,
  output logic [AW-1:0] sbr_q_o
);
  localparam logic [AW-1:0] RST_VAL = RST_ADDR[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q_o <= RST_VAL;
      sbr_q_o <= '0;
    end else begin
      car_q_o <= car_d_i;
      if (sbr_we_i) sbr_q_o <= link_i;
    end
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 16,
  parameter int UW_W     = 20,
  parameter int OPC_W    = 4,
  parameter int OPC_LSB  = 11,
  parameter int RST_ADDR = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [UW_W-1:0] uword_i,
  input  logic [DW-1:0]   dr_i,
  input  logic [DW-1:0]   ac_i,
  output logic [AW-1:0]   car_o
);
  localparam int BR_LSB = AW;
  localparam int CD_LSB = AW + 2;
  localparam int FLD_W  = AW + 4;

  logic [AW-1:0]    ad;
  br_kind_e         br;
  cond_sel_e        cd;
  logic             cond;
  logic [AW-1:0]    car_d;
  logic [AW-1:0]    link;
  logic             sbr_we;
  logic [AW-1:0]    sbr_q;
  logic [OPC_W-1:0] opc;
  logic             unused_bits;

  assign ad  = uword_i[AW-1:0];
  assign br  = br_kind_e'(uword_i[BR_LSB+1:BR_LSB]);
  assign cd  = cond_sel_e'(uword_i[CD_LSB+1:CD_LSB]);
  assign opc = dr_i[OPC_LSB+OPC_W-1:OPC_LSB];

  assign unused_bits = ^{uword_i[UW_W-1:FLD_W], dr_i[OPC_LSB-1:0]};

  useq_cond_sel #(.DW(DW)) u_cond (
    .sel_i  (cd),
    .ind_i  (dr_i[DW-1]),
    .ac_i   (ac_i),
    .cond_o (cond)
  );

  useq_next_addr #(.AW(AW), .OPC_W(OPC_W)) u_next (
    .br_i     (br),
    .cond_i   (cond),
    .ad_i     (ad),
    .car_i    (car_o),
    .sbr_i    (sbr_q),
    .opc_i    (opc),
    .car_d_o  (car_d),
    .link_o   (link),
    .sbr_we_o (sbr_we)
  );

  useq_addr_reg #(.AW(AW), .RST_ADDR(RST_ADDR)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .car_d_i  (car_d),
    .sbr_we_i (sbr_we),
    .link_i   (link),
    .car_q_o  (car_o),
    .sbr_q_o  (sbr_q)
  );
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW      = 7,
  parameter int DW      = 16,
  parameter int UW_W    = 20,
  parameter int OPC_W   = 4,
  parameter int OPC_LSB = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [UW_W-1:0] uword_i,
  input logic [DW-1:0]   dr_i,
  input logic [DW-1:0]   ac_i,
  input logic [AW-1:0]   car_o,
  input logic [AW-1:0]   sbr_i
);
  logic [1:0]    br;
  logic [1:0]    cd;
  logic [AW-1:0] ad;
  logic          cnd;
  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_exp;
  logic          unused_chk;

  assign ad      = uword_i[AW-1:0];
  assign br      = uword_i[AW+1:AW];
  assign cd      = uword_i[AW+3:AW+2];
  assign car_inc = car_o + 1'b1;
  assign unused_chk = ^{uword_i[UW_W-1:AW+4], dr_i[OPC_LSB-1:0], dr_i[DW-2:OPC_LSB+OPC_W]};

  always_comb begin
    case (cd)
      2'b00:   cnd = 1'b1;
      2'b01:   cnd = dr_i[DW-1];
      2'b10:   cnd = ac_i[DW-1];
      default: cnd = (ac_i == '0);
    endcase
    map_exp = '0;
    for (int i = 0; i < OPC_W; i++)
      if (i + 2 < AW) map_exp[i+2] = dr_i[OPC_LSB+i];
  end

  AST_JUMP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == 2'b00 && cnd) |=> car_o == $past(ad)); // R4

  AST_STEP_ON_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br[1] == 1'b0 && !cnd) |=> car_o == $past(car_inc)); // R8

  AST_CALL_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == 2'b01 && cnd) |=> (car_o == $past(ad) && sbr_i == $past(car_inc))); // R5

  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == 2'b10) |=> car_o == $past(sbr_i)); // R6

  AST_MAP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == 2'b11) |=> car_o == $past(map_exp)); // R7

  AST_SBR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br == 2'b01 && cnd) |=> $stable(sbr_i)); // R9
endmodule

bind useq_sequencer useq_sequencer_chk #(
  .AW(AW), .DW(DW), .UW_W(UW_W), .OPC_W(OPC_W), .OPC_LSB(OPC_LSB)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .uword_i (uword_i),
  .dr_i    (dr_i),
  .ac_i    (ac_i),
  .car_o   (car_o),
  .sbr_i   (sbr_q)
);

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [19:0] uword_i;
  logic [15:0] dr_i;
  logic [15:0] ac_i;
  logic [6:0]  car_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  useq_sequencer u_useq_sequencer (
    .clk_i(clk_i), .rst_ni(rst_ni), .uword_i(uword_i),
    .dr_i(dr_i), .ac_i(ac_i), .car_o(car_o)
  );

  function automatic logic [19:0] mk(input logic [8:0] f, input logic [1:0] cd,
                                     input logic [1:0] br, input logic [6:0] ad);
    return {f, cd, br, ad};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s car_o actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Drive at a falling edge, return at the next falling edge
  task automatic step(input logic [1:0] cd, input logic [1:0] br, input logic [6:0] ad);
    uword_i = mk(9'h0A5, cd, br, ad);
    @(negedge clk_i);
  endtask

  task automatic go(input logic [6:0] a);
    step(2'b00, 2'b00, a);
  endtask

  task automatic t_reset;
    rst_ni = 1'b1; uword_i = '0; dr_i = '0; ac_i = 16'h1234;
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 reset address", car_o, 7'd64);
    rst_ni = 1'b1;
    step(2'b00, 2'b10, 7'd9);
    check("R1 return register cleared", car_o, 7'd0);
  endtask

  task automatic t_fields;
    uword_i = {9'h1FF, 2'b00, 2'b00, 7'h15};
    @(negedge clk_i);
    check("R2 upper bits set, target taken", car_o, 7'h15);
    uword_i = {9'h000, 2'b00, 2'b00, 7'h2A};
    @(negedge clk_i);
    check("R2 upper bits clear, target taken", car_o, 7'h2A);
  endtask

  task automatic t_cond;
    dr_i = 16'h8000; ac_i = 16'h0001;
    go(7'd20); step(2'b01, 2'b00, 7'd50);
    check("R3 indirect true", car_o, 7'd50);
    dr_i = 16'h7FFF;
    go(7'd20); step(2'b01, 2'b00, 7'd50);
    check("R3 indirect false", car_o, 7'd21);
    ac_i = 16'h8000;
    go(7'd20); step(2'b10, 2'b00, 7'd51);
    check("R3 sign true", car_o, 7'd51);
    go(7'd20); step(2'b11, 2'b00, 7'd52);
    check("R3 zero false on 0x8000", car_o, 7'd21);
    ac_i = 16'h0000;
    go(7'd20); step(2'b11, 2'b00, 7'd52);
    check("R3 zero true", car_o, 7'd52);
    go(7'd20); step(2'b10, 2'b00, 7'd53);
    check("R4 sign false steps", car_o, 7'd21);
  endtask

  task automatic t_call;
    dr_i = 16'h0000; ac_i = 16'h0001;
    go(7'd10); step(2'b00, 2'b01, 7'd40);
    check("R5 call target", car_o, 7'd40);
    step(2'b01, 2'b01, 7'd90);
    check("R5 call not taken steps", car_o, 7'd41);
    step(2'b00, 2'b10, 7'd3);
    check("R9 not-taken call keeps link", car_o, 7'd11);
    go(7'd30); step(2'b00, 2'b01, 7'd44);
    go(7'd70); step(2'b00, 2'b01, 7'd45);
    step(2'b00, 2'b10, 7'd0);
    check("R9 second call overwrites link", car_o, 7'd71);
  endtask

  task automatic t_ret_cond;
    dr_i = 16'h0000;
    go(7'd5); step(2'b00, 2'b01, 7'd60);
    step(2'b01, 2'b10, 7'd99);
    check("R6 return ignores false condition", car_o, 7'd6);
  endtask

  task automatic t_map;
    dr_i = {1'b0, 4'hF, 11'h7FF};
    step(2'b01, 2'b11, 7'd1);
    check("R7 opcode 15", car_o, 7'd60);
    dr_i = {1'b0, 4'h0, 11'h7FF};
    step(2'b01, 2'b11, 7'd1);
    check("R7 opcode 0", car_o, 7'd0);
    dr_i = {1'b1, 4'h9, 11'h000};
    step(2'b01, 2'b11, 7'd127);
    check("R7 opcode 9 with true condition", car_o, 7'd36);
  endtask

  task automatic t_wrap;
    ac_i = 16'h0001;
    go(7'd127); step(2'b11, 2'b00, 7'd5);
    check("R8 step wraps", car_o, 7'd0);
    go(7'd127); step(2'b00, 2'b01, 7'd30);
    check("R8 call from top", car_o, 7'd30);
    step(2'b00, 2'b10, 7'd8);
    check("R8 link wraps", car_o, 7'd0);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_cond();
    t_call();
    t_ret_cond();
    t_map();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule